// File: doc/BRIEF.md
# Radix-4 Butterfly with Twiddle Multiply

This block carries out one radix-4 decimation-in-frequency butterfly step of a 16-point transform. On each valid cycle it accepts four complex samples whose sequence positions lie a quarter-transform apart (for example 0, 4, 8 and 12). It returns the four transformed outputs side by side. A network of eight complex adders and subtractors forms the outputs in two registered levels. Both ±j rotations are built from a swap of real and imaginary parts with one negation, so they need no multiplier.

Outputs 1, 2 and 3 then pass through a complex multiplier. Each multiplier uses a root of unity picked by a 4-bit exponent that the caller supplies along with the samples. Output 0 skips the multiply and is only saturated. The surrounding controller feeds one group per cycle and picks the exponents for the group. For the first pass of a 16-point transform these are n, 2n and 3n for group n. A valid flag moves through the pipeline beside the data. The result of a valid input appears three cycles later.

Top module: `radix4_bfly_tw`

## Requirements
- R1: Each 16-bit complex word carries its real part in bits [15:8] and its imaginary part in bits [7:0], both 8-bit two's complement, on inputs and outputs alike.
- R2: Output 0 equals a+b+c+d, with each component saturated to the range -128..127.
- R3: Output 2 equals (a-b+c-d) multiplied by the twiddle selected by the second exponent.
- R4: Output 1 equals (a-jb-c+jd) multiplied by the twiddle selected by the first exponent.
- R5: Output 3 equals (a+jb-c-jd) multiplied by the twiddle selected by the third exponent.
- R6: An exponent k (0..15) selects W = cos(2πk/16) - j·sin(2πk/16) as signed 8-bit constants with 6 fraction bits, each rounded to the nearest integer (64 stands for 1.0). For example k=1 gives (59, -24) and k=4 gives (0, -64).
- R7: Each twiddle product component is formed at full precision, then 32 is added, then it is shifted right arithmetically by 6 bits, then saturated to -128..127. Exponent 0 thus returns the butterfly sum saturated, with no change in value.
- R8: out_valid is high in the cycle that follows the third rising edge after a cycle in which in_valid was sampled high. That cycle carries that input's results. Consecutive valid inputs give consecutive results.
- R9: While out_valid is low, all four output words keep their previous values.
- R10: During reset and after its release, out_valid is 0 and all output words are 0 until the first result arrives.
- R11: Samples and exponents are taken only in cycles where in_valid is high. Values present in other cycles do not affect any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Marks a cycle whose samples and exponents are to be processed |
| in_a | input | 16 | Sample at position n |
| in_b | input | 16 | Sample at position n+N/4 |
| in_c | input | 16 | Sample at position n+2N/4 |
| in_d | input | 16 | Sample at position n+3N/4 |
| tw_exp1 | input | 4 | Twiddle exponent for output 1 |
| tw_exp2 | input | 4 | Twiddle exponent for output 2 |
| tw_exp3 | input | 4 | Twiddle exponent for output 3 |
| out_valid | output | 1 | Marks a cycle carrying a result |
| out_x0 | output | 16 | Output 0, no twiddle multiply |
| out_x1 | output | 16 | Output 1 after twiddle |
| out_x2 | output | 16 | Output 2 after twiddle |
| out_x3 | output | 16 | Output 3 after twiddle |

## Verification
The hardest conditions to reach are the saturation bounds, and in particular a twiddle of -1 applied to a butterfly sum that already exceeds eight bits. Ordinary data never drives the rounding step past the limits. The stimulus therefore uses extreme alternating samples (127 and -128) with exponents 0 and 8. Those samples push output 2 to ±510 before rounding. An impulse is also swept through all sixteen exponents back to back, so every quadrant of the twiddle generator is checked. Between valid cycles the bench drives random samples and exponents to show that idle-cycle values never reach a result.

// File: rtl/r4bf_pkg.sv
package r4bf_pkg;

  localparam int DATA_W  = 8;
  localparam int SMP_W   = 2 * DATA_W;
  localparam int L1_W    = DATA_W + 1;
  localparam int L2_W    = DATA_W + 2;
  localparam int TW_W    = 8;
  localparam int TW_FRAC = 6;
  localparam int EXP_W   = 4;
  localparam int PROD_W  = L2_W + TW_W + 1;
  localparam int N_OUT   = 4;

  localparam int SMP_MAXI = 2 ** (DATA_W - 1) - 1;
  localparam logic signed [DATA_W-1:0] SMP_HI  = DATA_W'(SMP_MAXI);
  localparam logic signed [DATA_W-1:0] SMP_LO  = DATA_W'(-SMP_MAXI - 1);
  localparam logic signed [L2_W-1:0]   L2_HI   = L2_W'(SMP_MAXI);
  localparam logic signed [L2_W-1:0]   L2_LO   = L2_W'(-SMP_MAXI - 1);
  localparam logic signed [PROD_W-1:0] PROD_HI = PROD_W'(SMP_MAXI);
  localparam logic signed [PROD_W-1:0] PROD_LO = PROD_W'(-SMP_MAXI - 1);
  localparam logic signed [PROD_W-1:0] PROD_RND = PROD_W'(2 ** (TW_FRAC - 1));

  typedef struct packed {
    logic signed [DATA_W-1:0] re;
    logic signed [DATA_W-1:0] im;
  } smp_t;

  typedef struct packed {
    logic signed [L1_W-1:0] re;
    logic signed [L1_W-1:0] im;
  } l1_t;

  typedef struct packed {
    logic signed [L2_W-1:0] re;
    logic signed [L2_W-1:0] im;
  } l2_t;

  typedef struct packed {
    logic signed [TW_W-1:0] re;
    logic signed [TW_W-1:0] im;
  } tw_t;

  // Clamp a second-level sum to the sample range.
  function automatic logic signed [DATA_W-1:0] sat_l2(input logic signed [L2_W-1:0] v);
    if (v > L2_HI)      return SMP_HI;
    else if (v < L2_LO) return SMP_LO;
    else                return v[DATA_W-1:0];
  endfunction

  // Round half up by the twiddle fraction, then clamp.
  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [PROD_W-1:0] v);
    logic signed [PROD_W-1:0] r;
    r = (v + PROD_RND) >>> TW_FRAC;
    if (r > PROD_HI)      return SMP_HI;
    else if (r < PROD_LO) return SMP_LO;
    else                  return r[DATA_W-1:0];
  endfunction

endpackage

// File: rtl/r4bf_level1.sv
// First adder level: sum and difference of the two sample pairs (a,c) and (b,d).
module r4bf_level1
  import r4bf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  smp_t a,
  input  smp_t b,
  input  smp_t c,
  input  smp_t d,
  output logic out_vld,
  output l1_t  sum_o [2],
  output l1_t  dif_o [2]
);

  smp_t lo [2];
  smp_t hi [2];
  logic vld_q;

  assign lo[0] = a;
  assign hi[0] = c;
  assign lo[1] = b;
  assign hi[1] = d;

  for (genvar g = 0; g < 2; g++) begin : g_pair
    l1_t s_d, s_q, d_d, d_q;

    always_comb begin
      s_d.re = L1_W'(lo[g].re) + L1_W'(hi[g].re);
      s_d.im = L1_W'(lo[g].im) + L1_W'(hi[g].im);
      d_d.re = L1_W'(lo[g].re) - L1_W'(hi[g].re);
      d_d.im = L1_W'(lo[g].im) - L1_W'(hi[g].im);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        d_q <= '0;
      end else if (in_vld) begin
        s_q <= s_d;
        d_q <= d_d;
      end
    end

    assign sum_o[g] = s_q;
    assign dif_o[g] = d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  assign out_vld = vld_q;

endmodule

// File: rtl/r4bf_level2.sv
// Second adder level: combines the first-level results; the ±j term is a swap with one negation.
module r4bf_level2
  import r4bf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  l1_t  sum_i [2],
  input  l1_t  dif_i [2],
  output logic out_vld,
  output l2_t  x_o [N_OUT]
);

  l2_t  p_ac, p_bd, m_ac, rot_nj;
  l2_t  x_d [N_OUT];
  l2_t  x_q [N_OUT];
  logic vld_q;

  always_comb begin
    p_ac.re = L2_W'(sum_i[0].re);
    p_ac.im = L2_W'(sum_i[0].im);
    p_bd.re = L2_W'(sum_i[1].re);
    p_bd.im = L2_W'(sum_i[1].im);
    m_ac.re = L2_W'(dif_i[0].re);
    m_ac.im = L2_W'(dif_i[0].im);
    // -j * (b - d): real takes the imaginary part, imaginary takes the negated real part
    rot_nj.re = L2_W'(dif_i[1].im);
    rot_nj.im = -L2_W'(dif_i[1].re);

    x_d[0].re = p_ac.re + p_bd.re;
    x_d[0].im = p_ac.im + p_bd.im;
    x_d[1].re = m_ac.re + rot_nj.re;
    x_d[1].im = m_ac.im + rot_nj.im;
    x_d[2].re = p_ac.re - p_bd.re;
    x_d[2].im = p_ac.im - p_bd.im;
    x_d[3].re = m_ac.re - rot_nj.re;
    x_d[3].im = m_ac.im - rot_nj.im;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      x_q[k] <= '0;
      else if (in_vld) x_q[k] <= x_d[k];
    end
    assign x_o[k] = x_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  assign out_vld = vld_q;

endmodule

// File: rtl/r4bf_twiddle_rom.sv
// Roots of unity for a 16-point transform: a first-quadrant table rotated by -j per quadrant.
module r4bf_twiddle_rom
  import r4bf_pkg::*;
(
  input  logic [EXP_W-1:0] exp_i,
  output tw_t              w
);

  logic signed [TW_W-1:0] cos_b, sin_b;
  int mag;

  always_comb begin
    unique case (exp_i[1:0])
      2'd0:    begin cos_b = TW_W'(64); sin_b = TW_W'(0);  end
      2'd1:    begin cos_b = TW_W'(59); sin_b = TW_W'(24); end
      2'd2:    begin cos_b = TW_W'(45); sin_b = TW_W'(45); end
      default: begin cos_b = TW_W'(24); sin_b = TW_W'(59); end
    endcase
    unique case (exp_i[3:2])
      2'd0:    begin w.re = cos_b;  w.im = -sin_b; end
      2'd1:    begin w.re = -sin_b; w.im = -cos_b; end
      2'd2:    begin w.re = -cos_b; w.im = sin_b;  end
      default: begin w.re = sin_b;  w.im = cos_b;  end
    endcase
  end

  // R6: every generated constant lies close to the unit circle (64^2 = 4096)
  always_comb begin
    mag = int'(w.re) * int'(w.re) + int'(w.im) * int'(w.im);
    if (!$isunknown(w)) begin
      a_r6_unit_circle: assert (mag >= 4000 && mag <= 4160);
    end
  end

endmodule

// File: rtl/r4bf_twiddle_mul.sv
// One complex twiddle multiply with round and saturate, registered.
module r4bf_twiddle_mul
  import r4bf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  l2_t              x,
  input  logic [EXP_W-1:0] exp_i,
  output smp_t             y
);

  tw_t  w;
  logic signed [PROD_W-1:0] rr, ii, ri, ir, acc_re, acc_im;
  smp_t y_d, y_q;

  r4bf_twiddle_rom u_rom (
    .exp_i (exp_i),
    .w     (w)
  );

  always_comb begin
    rr     = PROD_W'(x.re) * PROD_W'(w.re);
    ii     = PROD_W'(x.im) * PROD_W'(w.im);
    ri     = PROD_W'(x.re) * PROD_W'(w.im);
    ir     = PROD_W'(x.im) * PROD_W'(w.re);
    acc_re = rr - ii;
    acc_im = ri + ir;
    y_d.re = round_sat(acc_re);
    y_d.im = round_sat(acc_im);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y_q <= '0;
    else if (en) y_q <= y_d;
  end

  assign y = y_q;

  // R7: a unit twiddle leaves the butterfly sum unchanged apart from saturation
  a_r7_unity_twiddle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && exp_i == '0) |=> (y.re == sat_l2($past(x.re)) && y.im == sat_l2($past(x.im))));

endmodule

// File: rtl/radix4_bfly_tw.sv
module radix4_bfly_tw
  import r4bf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_a,
  input  logic [SMP_W-1:0] in_b,
  input  logic [SMP_W-1:0] in_c,
  input  logic [SMP_W-1:0] in_d,
  input  logic [EXP_W-1:0] tw_exp1,
  input  logic [EXP_W-1:0] tw_exp2,
  input  logic [EXP_W-1:0] tw_exp3,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_x0,
  output logic [SMP_W-1:0] out_x1,
  output logic [SMP_W-1:0] out_x2,
  output logic [SMP_W-1:0] out_x3
);

  localparam int N_TW = N_OUT - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  // adder network
  logic v1, v2;
  l1_t  sum1 [2];
  l1_t  dif1 [2];
  l2_t  x2 [N_OUT];

  r4bf_level1 u_lvl1 (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .in_vld  (in_valid),
    .a       (smp_t'(in_a)),
    .b       (smp_t'(in_b)),
    .c       (smp_t'(in_c)),
    .d       (smp_t'(in_d)),
    .out_vld (v1),
    .sum_o   (sum1),
    .dif_o   (dif1)
  );

  r4bf_level2 u_lvl2 (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .in_vld  (v1),
    .sum_i   (sum1),
    .dif_i   (dif1),
    .out_vld (v2),
    .x_o     (x2)
  );

  // exponents follow their group through both adder levels
  logic [EXP_W-1:0] exp_in [N_TW];
  logic [EXP_W-1:0] exp_s1_q [N_TW];
  logic [EXP_W-1:0] exp_s2_q [N_TW];

  assign exp_in[0] = tw_exp1;
  assign exp_in[1] = tw_exp2;
  assign exp_in[2] = tw_exp3;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      exp_s1_q <= '{default: '0};
      exp_s2_q <= '{default: '0};
    end else begin
      if (in_valid) exp_s1_q <= exp_in;
      if (v1)       exp_s2_q <= exp_s1_q;
    end
  end

  // output stage: direct path for output 0, twiddle multiply for the rest
  smp_t y [N_OUT];
  logic vout_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    if (k == 0) begin : g_direct
      smp_t y_d, y_q;
      always_comb begin
        y_d.re = sat_l2(x2[k].re);
        y_d.im = sat_l2(x2[k].im);
      end
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) y_q <= '0;
        else if (v2)  y_q <= y_d;
      end
      assign y[k] = y_q;
    end else begin : g_twiddle
      smp_t y_o;
      r4bf_twiddle_mul u_mul (
        .clk   (clk),
        .rst_n (rst_n_i),
        .en    (v2),
        .x     (x2[k]),
        .exp_i (exp_s2_q[k-1]),
        .y     (y_o)
      );
      assign y[k] = y_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) vout_q <= 1'b0;
    else          vout_q <= v2;
  end

  assign out_valid = vout_q;
  assign out_x0    = y[0];
  assign out_x1    = y[1];
  assign out_x2    = y[2];
  assign out_x3    = y[3];

  // checks at the block edge
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)                since_rst <= '0;
    else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
  end

  // R8: a result leaves exactly three edges after its input was taken
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n_i)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R9: no result, no change on the output words
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n_i)
    !out_valid |-> $stable({out_x0, out_x1, out_x2, out_x3}));

endmodule

// File: tb/radix4_bfly_tw_test.sv
module radix4_bfly_tw_test;

  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_a, in_b, in_c, in_d;
  logic [3:0]  tw_exp1, tw_exp2, tw_exp3;
  logic        out_valid;
  logic [15:0] out_x0, out_x1, out_x2, out_x3;

  always #5 clk = ~clk;

  radix4_bfly_tw uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .in_d      (in_d),
    .tw_exp1   (tw_exp1),
    .tw_exp2   (tw_exp2),
    .tw_exp3   (tw_exp3),
    .out_valid (out_valid),
    .out_x0    (out_x0),
    .out_x1    (out_x1),
    .out_x2    (out_x2),
    .out_x3    (out_x3)
  );

  typedef struct {
    int    re [4];
    int    im [4];
    int    cyc;
    string tag;
  } item_t;

  item_t sb [$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    mon_en = 1'b0;
  bit    have_last = 1'b0;
  bit    done = 1'b0;
  logic [63:0] last_out;
  item_t mon_it;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sat8(int v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int tw_re(int k);
    return int'($floor(64.0 * $cos(2.0 * PI * k / 16.0) + 0.5));
  endfunction

  function automatic int tw_im(int k);
    return -int'($floor(64.0 * $sin(2.0 * PI * k / 16.0) + 0.5));
  endfunction

  function automatic int rnd_sat(int p);
    return sat8((p + 32) >>> 6);
  endfunction

  function automatic int hi8(logic [15:0] w);
    return int'($signed(w[15:8]));
  endfunction

  function automatic int lo8(logic [15:0] w);
    return int'($signed(w[7:0]));
  endfunction

  task automatic chk(input string what, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, expv);
    end
  endtask

  // driver: one valid cycle, expected result pushed to the scoreboard
  task automatic send(input int ar, input int ai, input int br, input int bi,
                      input int cr, input int ci, input int dr, input int di,
                      input int e1, input int e2, input int e3, input string tag);
    item_t it;
    int sr [4];
    int si [4];
    int e  [4];
    @(negedge clk);
    in_valid = 1'b1;
    in_a = {8'(ar), 8'(ai)};
    in_b = {8'(br), 8'(bi)};
    in_c = {8'(cr), 8'(ci)};
    in_d = {8'(dr), 8'(di)};
    tw_exp1 = 4'(e1);
    tw_exp2 = 4'(e2);
    tw_exp3 = 4'(e3);
    sr[0] = ar + br + cr + dr;  si[0] = ai + bi + ci + di;
    sr[1] = ar + bi - cr - di;  si[1] = ai - br - ci + dr;
    sr[2] = ar - br + cr - dr;  si[2] = ai - bi + ci - di;
    sr[3] = ar - bi - cr + di;  si[3] = ai + br - ci - dr;
    e[0] = 0; e[1] = e1 % 16; e[2] = e2 % 16; e[3] = e3 % 16;
    it.re[0] = sat8(sr[0]);
    it.im[0] = sat8(si[0]);
    for (int k = 1; k < 4; k++) begin
      it.re[k] = rnd_sat(sr[k] * tw_re(e[k]) - si[k] * tw_im(e[k]));
      it.im[k] = rnd_sat(sr[k] * tw_im(e[k]) + si[k] * tw_re(e[k]));
    end
    it.cyc = cyc + 3;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // idle cycles with random garbage on every data and exponent input (R11)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = 16'($urandom);
      in_b = 16'($urandom);
      in_c = 16'($urandom);
      in_d = 16'($urandom);
      tw_exp1 = 4'($urandom);
      tw_exp2 = 4'($urandom);
      tw_exp3 = 4'($urandom);
    end
  endtask

  // monitor: compares results, latency and idle hold
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk("R8 unexpected out_valid", 1, 0);
        end else begin
          mon_it = sb.pop_front();
          chk($sformatf("R8 latency [%s]", mon_it.tag), cyc, mon_it.cyc);
          chk($sformatf("R2 X0.re [%s]", mon_it.tag), hi8(out_x0), mon_it.re[0]);
          chk($sformatf("R2 X0.im [%s]", mon_it.tag), lo8(out_x0), mon_it.im[0]);
          chk($sformatf("R4 X1.re [%s]", mon_it.tag), hi8(out_x1), mon_it.re[1]);
          chk($sformatf("R4 X1.im [%s]", mon_it.tag), lo8(out_x1), mon_it.im[1]);
          chk($sformatf("R3 X2.re [%s]", mon_it.tag), hi8(out_x2), mon_it.re[2]);
          chk($sformatf("R3 X2.im [%s]", mon_it.tag), lo8(out_x2), mon_it.im[2]);
          chk($sformatf("R5 X3.re [%s]", mon_it.tag), hi8(out_x3), mon_it.re[3]);
          chk($sformatf("R5 X3.im [%s]", mon_it.tag), lo8(out_x3), mon_it.im[3]);
        end
      end else if (have_last) begin
        chk("R9 outputs held while idle", 1, int'({out_x0, out_x1, out_x2, out_x3} == last_out));
      end
      last_out  = {out_x0, out_x1, out_x2, out_x3};
      have_last = 1'b1;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a = '0; in_b = '0; in_c = '0; in_d = '0;
    tw_exp1 = '0; tw_exp2 = '0; tw_exp3 = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid in reset", int'(out_valid), 0);
    chk("R10 outputs in reset", int'({out_x0, out_x1, out_x2, out_x3} == 64'd0), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 out_valid after release", int'(out_valid), 0);
    chk("R10 outputs after release", int'({out_x0, out_x1, out_x2, out_x3} == 64'd0), 1);
    mon_en = 1'b1;

    // equal samples: only output 0 is non-zero
    send(10, 5, 10, 5, 10, 5, 10, 5, 0, 0, 0, "R2 equal samples");
    idle(2);

    // impulse on a with distinct exponents: every output is a times its twiddle (R6)
    send(100, -50, 0, 0, 0, 0, 0, 0, 1, 2, 3, "R6 impulse");
    idle(1);

    // sweep all sixteen exponents back to back, quadrant wrap included (R6, R8)
    for (int k = 0; k < 16; k++)
      send(40, 30, 0, 0, 0, 0, 0, 0, k, (k + 5) % 16, 15 - k, "R6 sweep");
    idle(2);

    // saturation at both rails (R7)
    send(127, 127, 127, 127, 127, 127, 127, 127, 0, 0, 0, "R7 positive rail");
    send(-128, -128, -128, -128, -128, -128, -128, -128, 0, 0, 0, "R7 negative rail");
    send(127, 127, -128, -128, 127, 127, -128, -128, 0, 0, 0, "R7 x2 unity");
    send(127, 127, -128, -128, 127, 127, -128, -128, 4, 8, 12, "R7 x2 negated");
    send(-128, 127, 127, -128, -128, 127, 127, -128, 2, 6, 10, "R7 rotated");
    idle(3);

    // garbage in idle cycles must not reach results (R11)
    send(-7, 33, 12, -90, 55, 4, -20, 18, 3, 6, 9, "R11 before garbage");
    idle(4);
    send(64, -64, -32, 16, 8, 120, -100, -1, 9, 6, 3, "R11 after garbage");
    idle(2);

    // first-pass groups of a 16-point transform, exponents n, 2n, 3n (R1)
    for (int n = 0; n < 4; n++)
      send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           n, 2 * n, 3 * n, "R1 group");
    idle(3);

    // random data, random exponents, random gaps
    for (int i = 0; i < 300; i++) begin
      send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
           "R1 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    chk("R8 all results delivered", sb.size(), 0);
    finish_run();
  end

endmodule